// File: doc/BRIEF.md
# Transmit Output Shift Path with Automatic Refill

This block is the transmit data path of a small programmable I/O engine. A host pushes words into a four-entry transmit queue through a bus port that accepts byte, halfword and word writes. Narrow writes are copied across the whole 32-bit entry. An output shift register feeds an OUT operation that asks for 1 to 32 bits in one cycle. The bits are handed back right-aligned on `out_data`, taken from either the LSB end or the MSB end of the register.

The register can refill itself from the queue in two ways. With automatic refill on, it reloads whenever the number of bits already shifted out reaches a programmed threshold. Whether or not that mode is on, it also reloads when an OUT request needs more bits than remain. When neither is possible, the request stalls with the shift count frozen. A sticky flag then records the stall until the host clears it, and a drain indicator shows when both storage stages are empty and the engine is waiting.

Top module: `osr_tx_path`

## Requirements
- R1: After reset the queue is empty (`tx_level` 0, `wr_ready` 1), `txstall` is 0 and the shift register is empty, so the first OUT request stalls.
- R2: `wr_size` 0 writes byte `wr_data[7:0]` into all four byte lanes. Value 1 writes halfword `wr_data[15:0]` into both halves. Values 2 and 3 write the full word.
- R3: The queue holds 4 entries. When full, `wr_ready` is 0 and a held write is neither stored nor lost. It enters once a slot frees, and entries leave in write order.
- R4: With `cfg_autopull` set, the register reloads from the queue head once the shifted-bit count reaches the threshold. A `cfg_pull_thresh` of 0 means 32. The reload happens in the same cycle as an OUT request or on the next clock edge. If the count is at or past the threshold and the queue is empty, OUT stalls even if bits remain.
- R5: With `cfg_shift_right` = 1, an OUT of n bits returns the n least significant bits of the register, and the register shifts right by n.
- R6: With `cfg_shift_right` = 0, an OUT of n bits returns the n most significant bits in `out_data[n-1:0]`, and the register shifts left by n.
- R7: `out_bits` values 1 to 31 request that many bits. Value 0 requests 32.
- R8: An OUT for more bits than remain, with the queue empty, gets `out_ack` 0. The shift count is unchanged, so a later smaller request returns the untouched remaining bits.
- R9: An OUT for more bits than remain, with the queue non-empty, discards the leftover bits and is served from the next queue word in the same cycle.
- R10: `txstall` goes to 1 on the clock edge after a stalled OUT request and stays 1 until a `stall_clear` pulse. A stall in the same cycle as the clear wins.
- R11: `drained` is 1 only while the queue is empty, the register is empty, and an OUT request is stalled. The register counts as empty when all 32 bits have been shifted, or, with automatic refill on, when the threshold has been reached.
- R12: `restart` empties the shift register and sets its count to empty. The queue contents are kept, and no OUT is served in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| restart | input | 1 | Empties the shift register, keeps the queue |
| wr_valid | input | 1 | Host write request |
| wr_size | input | 2 | 0 byte, 1 halfword, 2/3 word |
| wr_data | input | 32 | Host write data |
| wr_ready | output | 1 | Queue can accept a write |
| tx_level | output | 3 | Number of queued words |
| cfg_autopull | input | 1 | Enables threshold refill |
| cfg_shift_right | input | 1 | 1 = bits leave at LSB end, 0 = at MSB end |
| cfg_pull_thresh | input | 5 | Refill threshold in bits, 0 means 32 |
| out_req | input | 1 | OUT request strobe |
| out_bits | input | 5 | Bits requested, 0 means 32 |
| out_ack | output | 1 | OUT request served this cycle |
| out_data | output | 32 | Requested bits, right-aligned |
| stall_clear | input | 1 | Clears the sticky stall flag |
| txstall | output | 1 | Sticky stall flag |
| drained | output | 1 | Queue and register empty with OUT waiting |

## Verification
A wrong shift count shows up on the first OUT after it goes wrong. The request is either served from stale bits when it should have reloaded, or it stalls when data was available. In both cases the error appears in the same cycle on `out_data` or `out_ack`. A queue pointer or level fault shows in `out_data` when the affected word reaches the head. It can also show one cycle after a write as a wrong `tx_level` or a missing `wr_ready`. A fault in the sticky flag becomes visible one edge after the stall or clear that should have changed it.

// File: rtl/osrp_pkg.sv
package osrp_pkg;
    localparam int DATA_W = 32;
    localparam int CNT_W  = $clog2(DATA_W + 1);
    localparam int THR_W  = $clog2(DATA_W);

    typedef enum logic [1:0] {
        WR_BYTE = 2'd0,
        WR_HALF = 2'd1,
        WR_WORD = 2'd2,
        WR_WORD_ALT = 2'd3
    } wr_size_e;

    function automatic logic [DATA_W-1:0] lane_fill(input logic [1:0] size,
                                                    input logic [DATA_W-1:0] d);
        logic [DATA_W-1:0] r;
        case (size)
            WR_BYTE: r = {(DATA_W/8){d[7:0]}};
            WR_HALF: r = {(DATA_W/16){d[15:0]}};
            default: r = d;
        endcase
        return r;
    endfunction
endpackage

// File: rtl/osr_txq.sv
module osr_txq
    import osrp_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LW = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [1:0]        wr_size,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_ready,
    input  logic              pop,
    output logic [DATA_W-1:0] head,
    output logic              empty,
    output logic [LW-1:0]     level
);
    typedef struct packed {
        logic [DEPTH-1:0][DATA_W-1:0] mem;
        logic [PW-1:0]                wp;
        logic [PW-1:0]                rp;
        logic [LW-1:0]                cnt;
    } q_st_t;

    q_st_t st_d, st_q;
    logic  push;
    logic  do_pop;

    always_comb begin
        st_d     = st_q;
        wr_ready = (st_q.cnt != LW'(DEPTH));
        empty    = (st_q.cnt == '0);
        push     = wr_valid && wr_ready;
        do_pop   = pop && !empty;
        head     = st_q.mem[st_q.rp];
        level    = st_q.cnt;
        if (push) begin
            st_d.mem[st_q.wp] = lane_fill(wr_size, wr_data);
            st_d.wp = (st_q.wp == PW'(DEPTH - 1)) ? '0 : st_q.wp + 1'b1;
        end
        if (do_pop) begin
            st_d.rp = (st_q.rp == PW'(DEPTH - 1)) ? '0 : st_q.rp + 1'b1;
        end
        st_d.cnt = st_q.cnt + LW'(push) - LW'(do_pop);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R3: level never exceeds the depth
    p_level_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= LW'(DEPTH));
    // R3: a full queue without a pop stays full (held write not stored)
    p_full_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt == LW'(DEPTH) && !pop) |=> (st_q.cnt == LW'(DEPTH)));
endmodule

// File: rtl/osr_shifter.sv
module osr_shifter
    import osrp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              autopull,
    input  logic              shift_right,
    input  logic [THR_W-1:0]  pull_thresh,
    input  logic              out_req,
    input  logic [THR_W-1:0]  out_bits,
    input  logic              q_empty,
    input  logic [DATA_W-1:0] q_head,
    input  logic              stall_clear,
    output logic              q_pop,
    output logic              out_ack,
    output logic [DATA_W-1:0] out_data,
    output logic              txstall,
    output logic              drained
);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(DATA_W);

    typedef struct packed {
        logic [DATA_W-1:0] osr;
        logic [CNT_W-1:0]  cnt;
        logic              stk;
    } sh_st_t;

    sh_st_t            st_d, st_q;
    logic [CNT_W-1:0]  thr_eff, n_eff, cnt_eff;
    logic [DATA_W-1:0] osr_eff, mask;
    logic              due, short_q, refill, blocked, stall;

    always_comb begin
        st_d    = st_q;
        thr_eff = (pull_thresh == '0) ? FULL : {1'b0, pull_thresh};
        n_eff   = (out_bits == '0) ? FULL : {1'b0, out_bits};
        due     = autopull && (st_q.cnt >= thr_eff);
        short_q = out_req && (n_eff > (FULL - st_q.cnt));
        refill  = !restart && !q_empty && (due || short_q);
        osr_eff = refill ? q_head : st_q.osr;
        cnt_eff = refill ? '0 : st_q.cnt;
        blocked = (due && !refill) || (n_eff > (FULL - cnt_eff));
        out_ack = out_req && !restart && !blocked;
        stall   = out_req && !restart && blocked;
        q_pop   = refill;
        mask    = (n_eff == FULL) ? '1 : ((DATA_W'(1) << n_eff) - DATA_W'(1));
        out_data = shift_right ? (osr_eff & mask) : (osr_eff >> (FULL - n_eff));
        drained = q_empty && stall && ((st_q.cnt == FULL) || due);

        if (restart) begin
            st_d.osr = '0;
            st_d.cnt = FULL;
        end else if (out_ack) begin
            st_d.osr = shift_right ? (osr_eff >> n_eff) : (osr_eff << n_eff);
            st_d.cnt = cnt_eff + n_eff;
        end else begin
            st_d.osr = osr_eff;
            st_d.cnt = cnt_eff;
        end

        if (stall)            st_d.stk = 1'b1;
        else if (stall_clear) st_d.stk = 1'b0;
        txstall = st_q.stk;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.cnt <= FULL;
        end else begin
            st_q <= st_d;
        end
    end

    // R8: count stays in range
    p_cnt_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= FULL);
    // R8: an unserved request leaves the shift count untouched
    p_stall_keeps_cnt_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_req && !out_ack && !restart) |=> $stable(st_q.cnt));
    // R12: restart leaves the register empty
    p_restart_empty_r12: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (st_q.cnt == FULL));
    // R10: sticky flag holds without a clear
    p_sticky_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (txstall && !stall_clear) |=> txstall);
    // R11: drained never coincides with a served request
    p_drained_no_ack_r11: assert property (@(posedge clk) disable iff (!rst_n)
        drained |-> (!out_ack && q_empty));
endmodule

// File: rtl/osr_tx_path.sv
module osr_tx_path
    import osrp_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int LW = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              wr_valid,
    input  logic [1:0]        wr_size,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_ready,
    output logic [LW-1:0]     tx_level,
    input  logic              cfg_autopull,
    input  logic              cfg_shift_right,
    input  logic [THR_W-1:0]  cfg_pull_thresh,
    input  logic              out_req,
    input  logic [THR_W-1:0]  out_bits,
    output logic              out_ack,
    output logic [DATA_W-1:0] out_data,
    input  logic              stall_clear,
    output logic              txstall,
    output logic              drained
);
    logic              q_pop, q_empty;
    logic [DATA_W-1:0] q_head;

    osr_txq #(.DEPTH(DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n),
        .wr_valid(wr_valid), .wr_size(wr_size), .wr_data(wr_data),
        .wr_ready(wr_ready), .pop(q_pop), .head(q_head),
        .empty(q_empty), .level(tx_level)
    );

    osr_shifter u_shift (
        .clk(clk), .rst_n(rst_n), .restart(restart),
        .autopull(cfg_autopull), .shift_right(cfg_shift_right),
        .pull_thresh(cfg_pull_thresh), .out_req(out_req), .out_bits(out_bits),
        .q_empty(q_empty), .q_head(q_head), .stall_clear(stall_clear),
        .q_pop(q_pop), .out_ack(out_ack), .out_data(out_data),
        .txstall(txstall), .drained(drained)
    );

    // R9: a pop only happens when the queue holds data
    p_pop_nonempty_r9: assert property (@(posedge clk) disable iff (!rst_n)
        q_pop |-> (tx_level != '0));
endmodule

// File: tb/osr_tx_path_tb.sv
module osr_tx_path_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        restart = 1'b0;
    logic        wr_valid = 1'b0;
    logic [1:0]  wr_size = 2'd2;
    logic [31:0] wr_data = '0;
    logic        wr_ready;
    logic [2:0]  tx_level;
    logic        cfg_autopull = 1'b0;
    logic        cfg_shift_right = 1'b1;
    logic [4:0]  cfg_pull_thresh = 5'd0;
    logic        out_req = 1'b0;
    logic [4:0]  out_bits = 5'd0;
    logic        out_ack;
    logic [31:0] out_data;
    logic        stall_clear = 1'b0;
    logic        txstall;
    logic        drained;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    osr_tx_path u_dut (
        .clk(clk), .rst_n(rst_n), .restart(restart),
        .wr_valid(wr_valid), .wr_size(wr_size), .wr_data(wr_data),
        .wr_ready(wr_ready), .tx_level(tx_level),
        .cfg_autopull(cfg_autopull), .cfg_shift_right(cfg_shift_right),
        .cfg_pull_thresh(cfg_pull_thresh), .out_req(out_req), .out_bits(out_bits),
        .out_ack(out_ack), .out_data(out_data), .stall_clear(stall_clear),
        .txstall(txstall), .drained(drained)
    );

    // {size[2], data[32], shift_right[1], nbits[5], expected[32]}
    localparam logic [71:0] VEC [8] = '{
        {2'd2, 32'h12345678, 1'b1, 5'd8,  32'h00000078},
        {2'd2, 32'h12345678, 1'b0, 5'd8,  32'h00000012},
        {2'd0, 32'hFFFFFFA5, 1'b1, 5'd0,  32'hA5A5A5A5},
        {2'd1, 32'h1234BEEF, 1'b0, 5'd16, 32'h0000BEEF},
        {2'd1, 32'h000000C3, 1'b1, 5'd0,  32'h00C300C3},
        {2'd2, 32'h80000001, 1'b0, 5'd1,  32'h00000001},
        {2'd3, 32'h80000001, 1'b1, 5'd4,  32'h00000001},
        {2'd0, 32'h0000003C, 1'b0, 5'd4,  32'h00000003}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [1:0] sz, input logic [31:0] d);
        wr_valid = 1'b1; wr_size = sz; wr_data = d;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic do_restart();
        restart = 1'b1;
        @(negedge clk);
        restart = 1'b0;
    endtask

    task automatic do_out(input string req, input logic [4:0] n,
                          input logic exp_ack, input logic [31:0] exp);
        out_req = 1'b1; out_bits = n;
        #2;
        chk(req, {31'd0, out_ack}, {31'd0, exp_ack});
        if (exp_ack) chk(req, out_data, exp);
        @(negedge clk);
        out_req = 1'b0;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #2;
        // R1 reset state
        chk("R1 ready", {31'd0, wr_ready}, 32'd1);
        chk("R1 level", {29'd0, tx_level}, 32'd0);
        chk("R1 txstall", {31'd0, txstall}, 32'd0);
        @(negedge clk);
        out_req = 1'b1; out_bits = 5'd4;
        #2;
        chk("R1 first out stalls", {31'd0, out_ack}, 32'd0);
        chk("R11 drained on empty", {31'd0, drained}, 32'd1);
        @(negedge clk);
        out_req = 1'b0;
        #2;
        chk("R10 txstall set", {31'd0, txstall}, 32'd1);
        @(negedge clk);
        chk("R10 txstall holds", {31'd0, txstall}, 32'd1);
        stall_clear = 1'b1;
        @(negedge clk);
        stall_clear = 1'b0;
        #2;
        chk("R10 txstall cleared", {31'd0, txstall}, 32'd0);
        @(negedge clk);

        // R2 R5 R6 R7 vector table
        foreach (VEC[i]) begin
            restart = 1'b1;
            wr_valid = 1'b1; wr_size = VEC[i][71:70]; wr_data = VEC[i][69:38];
            @(negedge clk);
            restart = 1'b0; wr_valid = 1'b0;
            cfg_shift_right = VEC[i][37];
            do_out($sformatf("R2/R5/R6/R7 vec%0d", i), VEC[i][36:32], 1'b1, VEC[i][31:0]);
        end

        // R3 full queue, held write, ordering
        cfg_shift_right = 1'b1;
        do_restart();
        for (int k = 1; k <= 4; k++) do_write(2'd2, 32'h11111111 * k);
        #2;
        chk("R3 full level", {29'd0, tx_level}, 32'd4);
        chk("R3 ready low", {31'd0, wr_ready}, 32'd0);
        wr_valid = 1'b1; wr_size = 2'd2; wr_data = 32'h55555555;
        repeat (2) @(negedge clk);
        #2;
        chk("R3 held write not stored", {29'd0, tx_level}, 32'd4);
        out_req = 1'b1; out_bits = 5'd0;
        #1;
        chk("R3 order word1", out_data, 32'h11111111);
        @(negedge clk);
        out_req = 1'b0;
        #2;
        chk("R3 ready after pop", {31'd0, wr_ready}, 32'd1);
        @(negedge clk);
        wr_valid = 1'b0;
        #2;
        chk("R3 held write entered", {29'd0, tx_level}, 32'd4);
        for (int k = 2; k <= 5; k++) do_out("R3 order", 5'd0, 1'b1, 32'h11111111 * k);
        do_out("R11 drained after drain", 5'd1, 1'b0, 32'd0);

        // R4 threshold refill
        do_restart();
        cfg_autopull = 1'b1; cfg_pull_thresh = 5'd8;
        do_write(2'd2, 32'h000000AB);
        do_write(2'd2, 32'h000000CD);
        @(negedge clk);
        do_out("R4 first word", 5'd8, 1'b1, 32'h000000AB);
        do_out("R4 reload at threshold", 5'd8, 1'b1, 32'h000000CD);
        out_req = 1'b1; out_bits = 5'd8;
        #2;
        chk("R4 stall at threshold with bits left", {31'd0, out_ack}, 32'd0);
        chk("R11 drained at threshold", {31'd0, drained}, 32'd1);
        @(negedge clk);
        out_req = 1'b0;

        // R4 R7 threshold 0 means 32
        do_restart();
        cfg_pull_thresh = 5'd0;
        do_write(2'd2, 32'h87654321);
        do_write(2'd2, 32'hFFFF000A);
        @(negedge clk);
        do_out("R4 thr0 low half", 5'd16, 1'b1, 32'h00004321);
        do_out("R4 thr0 no early reload", 5'd16, 1'b1, 32'h00008765);
        do_out("R4 thr0 reload at 32", 5'd4, 1'b1, 32'h0000000A);
        cfg_autopull = 1'b0;

        // R12 restart keeps queue
        do_restart();
        do_write(2'd2, 32'hAAAAAAAA);
        do_out("R12 setup", 5'd4, 1'b1, 32'h0000000A);
        do_write(2'd2, 32'h00000005);
        do_restart();
        #2;
        chk("R12 queue kept", {29'd0, tx_level}, 32'd1);
        do_out("R12 old bits gone", 5'd4, 1'b1, 32'h00000005);

        // R8 stall keeps count
        do_restart();
        do_write(2'd2, 32'h76543210);
        do_out("R8 setup", 5'd28, 1'b1, 32'h06543210);
        out_req = 1'b1; out_bits = 5'd8;
        #2;
        chk("R8 short stall", {31'd0, out_ack}, 32'd0);
        chk("R11 not drained with bits left", {31'd0, drained}, 32'd0);
        @(negedge clk);
        out_req = 1'b0;
        do_out("R8 remaining bits intact", 5'd4, 1'b1, 32'h00000007);
        do_write(2'd2, 32'h000000EE);
        do_out("R8 resumes after data", 5'd8, 1'b1, 32'h000000EE);

        // R9 on-demand reload discards leftovers
        do_restart();
        do_write(2'd2, 32'h11111111);
        do_write(2'd2, 32'h22222222);
        do_out("R9 setup", 5'd28, 1'b1, 32'h01111111);
        do_out("R9 reload on short", 5'd8, 1'b1, 32'h00000022);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule